// File: doc/BRIEF.md
# Interrupt translation command engine

This block turns message-signalled interrupts into physical interrupt IDs. It takes commands of four 64-bit words, one at a time, from a command queue front-end. The commands fill three small internal tables. The device table holds, per device, a valid flag and the width of its event-ID range. The collection table holds, per collection, a valid flag and a 32-bit target. The translation table holds, per (device, event) pair, a physical interrupt ID and a collection ID. A trigger command, or a message write carrying a device ID and an event ID, looks these tables up and presents the resulting interrupt ID and its target on a valid/ready output.

The block also handles a synchronisation command and an invalidate-all command. It rejects any mapping that could not later be translated, and it keeps two error indicators: a saturating count of rejected event mappings and a sticky flag for translations that missed. The engine works on one command or message at a time. While an interrupt output is waiting to be accepted, it blocks both of its inputs.

The table depths are parameters and must be powers of two. A device ID, event ID or collection ID at or beyond its table depth counts as unmapped. The translation table address carried by a device-map command is not used, because the translation storage is internal to the block.

Top module: `xlat_cmd_engine`

## Requirements
- R1: A device-map command (opcode 0x08) writes the device table entry for the device ID in word 0 bits [63:32]. The valid flag comes from word 2 bit 63 and the size from word 1 bits [4:0]. An event ID is in range for that device only when it is below 2^(size+1). Mapping a device with the valid flag clear makes all of its events untranslatable.
- R2: A collection-map command (opcode 0x09) writes the collection table entry for the collection ID in word 2 bits [15:0]. The valid flag comes from word 2 bit 63 and the target from word 2 bits [47:16]. Once a collection is unmapped, events routed to it no longer translate.
- R3: An event-map command (opcode 0x0A) binds the pair (device ID in word 0 bits [63:32], event ID in word 1 bits [31:0]) to the interrupt ID in word 1 bits [63:32] and the collection ID in word 2 bits [15:0]. A later trigger command (opcode 0x03) for that pair raises `irq_valid` on the cycle after it is accepted. At that point `irq_id` and `irq_target` carry the mapped values, and they hold steady until `irq_ready` is seen.
- R4: A message write (`msg_dev`, `msg_evt`) translates exactly like a trigger command. A pending command has priority: `msg_ready` is low whenever `cmd_valid` is high.
- R5: An event-map command whose interrupt ID is below 8192 creates no mapping and adds one to `err_count`. The value 8192 itself is accepted. `err_count` saturates and never moves by more than one per cycle.
- R6: An event-map command is also rejected, and adds one to `err_count`, when its device is unmapped, when its event ID is at or above 2^(size+1), or when its collection is unmapped.
- R7: A trigger command or message for a pair that does not translate raises no interrupt and sets `err_sticky`. `err_sticky` stays set until reset.
- R8: While `irq_valid` is high, both `cmd_ready` and `msg_ready` are low. `cmd_ready` returns high on the cycle after the interrupt is accepted.
- R9: A sync command (opcode 0x05) pulses `sync_done` for one cycle, on the cycle after it is accepted, with `sync_target` taken from word 2 bits [47:16]. `sync_done` is never high while an interrupt output is pending.
- R10: An invalidate-all command (opcode 0x0D) for a mapped collection pulses `inval_pulse` for one cycle after acceptance, with `inval_target` set to that collection's target. An unmapped collection produces no pulse.
- R11: The opcodes 0x01, 0x04, 0x0B, 0x0C, 0x0E and 0x0F, and any other undefined opcode, are accepted and change no table, no output and no error indicator.
- R12: After reset, every table entry is invalid, `cmd_ready` is high, `irq_valid`, `sync_done` and `inval_pulse` are low, `err_count` is zero and `err_sticky` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command words valid |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_words | input | 4x64 | Command words, index 0 is word 0 |
| msg_valid | input | 1 | Message write valid |
| msg_ready | output | 1 | Engine can take a message |
| msg_dev | input | 32 | Message device ID |
| msg_evt | input | 32 | Message event ID |
| irq_valid | output | 1 | Translated interrupt pending |
| irq_ready | input | 1 | Downstream accepts the interrupt |
| irq_id | output | 32 | Translated physical interrupt ID |
| irq_target | output | 32 | Target of the interrupt's collection |
| inval_pulse | output | 1 | One-cycle invalidate-all strobe |
| inval_target | output | 32 | Target for the invalidate strobe |
| sync_done | output | 1 | One-cycle sync completion |
| sync_target | output | 32 | Target carried by the sync command |
| err_count | output | ERR_W | Saturating count of rejected event maps |
| err_sticky | output | 1 | A translation missed since reset |

## Verification
The bench drives commands, checks every interrupt it sees against a scoreboard queue, and probes the boundaries that a design could get wrong:

- **Interrupt ID of exactly 8192 against 8191.** An off-by-one comparison would reject a legal mapping or accept an illegal one, and a later trigger would then go missing or appear unexpectedly.
- **Event IDs just past 2^(size+1) and devices beyond the table.** A range check that got these wrong would write entries that later produce spurious interrupts.
- **Unmapping a collection or device after its events are mapped.** A lookup that ignores either valid flag keeps translating the stale entry.
- **Holding `irq_ready` low.** A design that accepts new work, or changes the interrupt output, while the output is pending is caught at the ports.
- **Defined-but-unsupported opcodes carrying map-like fields.** A decoder that treats them as maps or as triggers produces an extra interrupt or a changed error count.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam logic [7:0] OP_TRIGGER  = 8'h03;
    localparam logic [7:0] OP_SYNC     = 8'h05;
    localparam logic [7:0] OP_DEV_MAP  = 8'h08;
    localparam logic [7:0] OP_COLL_MAP = 8'h09;
    localparam logic [7:0] OP_EVT_MAP  = 8'h0A;
    localparam logic [7:0] OP_INV_ALL  = 8'h0D;

    localparam logic [31:0] LOWEST_MSG_IRQ = 32'd8192;

    // Decoded command fields
    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] dev;
        logic [31:0] evt;
        logic [31:0] intid;
        logic [15:0] coll;
        logic [31:0] target;
        logic [4:0]  size;
        logic        vld;
    } cmd_t;

    typedef struct packed {
        logic       vld;
        logic [4:0] size;
    } dev_ent_t;

    typedef struct packed {
        logic        vld;
        logic [31:0] target;
    } coll_ent_t;

    typedef struct packed {
        logic        vld;
        logic [31:0] intid;
        logic [15:0] coll;
    } ite_ent_t;

    // Event fits in a range of 2^(size+1) identifiers
    function automatic logic evt_fits(logic [31:0] evt, logic [4:0] size);
        logic [5:0] sh;
        sh = {1'b0, size} + 6'd1;
        return (evt >> sh) == 32'd0;
    endfunction

endpackage

// File: rtl/xlat_cmd_decode.sv
module xlat_cmd_decode
    import xlat_pkg::*;
(
    input  logic [3:0][63:0] words,
    output cmd_t             cmd
);
    logic unused_bits;

    always_comb begin
        cmd.op     = words[0][7:0];
        cmd.dev    = words[0][63:32];
        cmd.evt    = words[1][31:0];
        cmd.intid  = words[1][63:32];
        cmd.size   = words[1][4:0];
        cmd.coll   = words[2][15:0];
        cmd.target = words[2][47:16];
        cmd.vld    = words[2][63];
    end

    // Reserved bits, table address and word 3 carry nothing the engine needs
    assign unused_bits = ^{words[0][31:8], words[2][62:48], words[3]};

endmodule

// File: rtl/xlat_table.sv
module xlat_table #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [$clog2(N)-1:0]      waddr,
    input  logic [W-1:0]              wdata,
    input  logic [$clog2(N)-1:0]      raddr,
    output logic [W-1:0]              rdata
);
    localparam int unsigned AW = $clog2(N);

    logic [W-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (we && waddr == AW'(g))
                ent[g] <= wdata;
        end
    end

    assign rdata = ent[raddr];

endmodule

// File: rtl/xlat_cmd_engine.sv
module xlat_cmd_engine
    import xlat_pkg::*;
#(
    parameter int unsigned DEV_N  = 4,
    parameter int unsigned EVT_N  = 8,
    parameter int unsigned COLL_N = 4,
    parameter int unsigned ERR_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0][63:0] cmd_words,
    input  logic             msg_valid,
    output logic             msg_ready,
    input  logic [31:0]      msg_dev,
    input  logic [31:0]      msg_evt,
    output logic             irq_valid,
    input  logic             irq_ready,
    output logic [31:0]      irq_id,
    output logic [31:0]      irq_target,
    output logic             inval_pulse,
    output logic [31:0]      inval_target,
    output logic             sync_done,
    output logic [31:0]      sync_target,
    output logic [ERR_W-1:0] err_count,
    output logic             err_sticky
);
    localparam int unsigned DIW   = $clog2(DEV_N);
    localparam int unsigned EIW   = $clog2(EVT_N);
    localparam int unsigned CIW   = $clog2(COLL_N);
    localparam int unsigned ITE_N = DEV_N * EVT_N;
    localparam int unsigned DEW   = $bits(dev_ent_t);
    localparam int unsigned CEW   = $bits(coll_ent_t);
    localparam int unsigned IEW   = $bits(ite_ent_t);

    cmd_t      dec;
    logic      cmd_fire, msg_fire, trig;
    logic [31:0] lk_dev, lk_evt;
    logic [15:0] coll_sel;
    logic      dev_in, evt_in, coll_in, evt_rng;
    logic      map_ok, hit;
    logic      dev_we, coll_we, ite_we;
    dev_ent_t  dev_rd;
    coll_ent_t coll_rd;
    ite_ent_t  ite_rd;
    logic [DEW-1:0] dev_raw;
    logic [CEW-1:0] coll_raw;
    logic [IEW-1:0] ite_raw;
    logic [DIW+EIW-1:0] ite_idx;

    xlat_cmd_decode u_dec (.words(cmd_words), .cmd(dec));

    assign cmd_ready = !irq_valid;
    assign msg_ready = !irq_valid && !cmd_valid;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign msg_fire  = msg_valid && msg_ready;
    assign trig      = (cmd_fire && dec.op == OP_TRIGGER) || msg_fire;

    // Shared lookup path: command fields win over message fields
    assign lk_dev   = cmd_fire ? dec.dev : msg_dev;
    assign lk_evt   = cmd_fire ? dec.evt : msg_evt;
    assign coll_sel = (cmd_fire && (dec.op == OP_EVT_MAP || dec.op == OP_COLL_MAP ||
                                    dec.op == OP_INV_ALL)) ? dec.coll : ite_rd.coll;

    assign dev_in  = lk_dev < DEV_N;
    assign evt_in  = lk_evt < EVT_N;
    assign coll_in = 32'(coll_sel) < COLL_N;
    assign ite_idx = {lk_dev[DIW-1:0], lk_evt[EIW-1:0]};

    assign dev_rd  = dev_ent_t'(dev_raw);
    assign coll_rd = coll_ent_t'(coll_raw);
    assign ite_rd  = ite_ent_t'(ite_raw);
    assign evt_rng = evt_fits(lk_evt, dev_rd.size);

    assign map_ok = dev_in && dev_rd.vld && evt_in && evt_rng &&
                    coll_in && coll_rd.vld && (dec.intid >= LOWEST_MSG_IRQ);
    assign hit    = dev_in && dev_rd.vld && evt_in && evt_rng &&
                    ite_rd.vld && coll_in && coll_rd.vld;

    assign dev_we  = cmd_fire && dec.op == OP_DEV_MAP && dev_in;
    assign coll_we = cmd_fire && dec.op == OP_COLL_MAP && coll_in;
    assign ite_we  = cmd_fire && dec.op == OP_EVT_MAP && map_ok;

    xlat_table #(.N(DEV_N), .W(DEW)) u_dev_tbl (
        .clk(clk), .rst(rst), .we(dev_we), .waddr(lk_dev[DIW-1:0]),
        .wdata(DEW'({dec.vld, dec.size})), .raddr(lk_dev[DIW-1:0]), .rdata(dev_raw));

    xlat_table #(.N(COLL_N), .W(CEW)) u_coll_tbl (
        .clk(clk), .rst(rst), .we(coll_we), .waddr(coll_sel[CIW-1:0]),
        .wdata(CEW'({dec.vld, dec.target})), .raddr(coll_sel[CIW-1:0]), .rdata(coll_raw));

    xlat_table #(.N(ITE_N), .W(IEW)) u_ite_tbl (
        .clk(clk), .rst(rst), .we(ite_we), .waddr(ite_idx),
        .wdata(IEW'({1'b1, dec.intid, dec.coll})), .raddr(ite_idx), .rdata(ite_raw));

    // Interrupt output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid  <= 1'b0;
            irq_id     <= '0;
            irq_target <= '0;
            err_sticky <= 1'b0;
        end else begin
            if (irq_valid && irq_ready)
                irq_valid <= 1'b0;
            if (trig) begin
                if (hit) begin
                    irq_valid  <= 1'b1;
                    irq_id     <= ite_rd.intid;
                    irq_target <= coll_rd.target;
                end else begin
                    err_sticky <= 1'b1;
                end
            end
        end
    end

    // Strobes and rejection counter
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_done    <= 1'b0;
            sync_target  <= '0;
            inval_pulse  <= 1'b0;
            inval_target <= '0;
            err_count    <= '0;
        end else begin
            sync_done   <= cmd_fire && dec.op == OP_SYNC;
            inval_pulse <= cmd_fire && dec.op == OP_INV_ALL && coll_in && coll_rd.vld;
            if (cmd_fire && dec.op == OP_SYNC)
                sync_target <= dec.target;
            if (cmd_fire && dec.op == OP_INV_ALL)
                inval_target <= coll_rd.target;
            if (cmd_fire && dec.op == OP_EVT_MAP && !map_ok && err_count != '1)
                err_count <= err_count + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_cmd_engine_chk.sv
module xlat_cmd_engine_chk #(
    parameter int unsigned ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             msg_ready,
    input logic             irq_valid,
    input logic             irq_ready,
    input logic [31:0]      irq_id,
    input logic [31:0]      irq_target,
    input logic             inval_pulse,
    input logic             sync_done,
    input logic [ERR_W-1:0] err_count,
    input logic             err_sticky
);
    p_irq_hold_r3: assert property (@(posedge clk) disable iff (rst)
        irq_valid && !irq_ready |=> irq_valid && $stable(irq_id) && $stable(irq_target));

    p_irq_floor_r5: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> irq_id >= 32'd8192);

    p_msg_yield_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !msg_ready);

    p_busy_block_r8: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !cmd_ready && !msg_ready);

    p_sync_idle_r9: assert property (@(posedge clk) disable iff (rst)
        sync_done |-> !irq_valid);

    p_inval_cause_r10: assert property (@(posedge clk) disable iff (rst)
        inval_pulse |-> $past(cmd_valid && cmd_ready));

    p_err_step_r6: assert property (@(posedge clk) disable iff (rst)
        err_count == $past(err_count) || err_count == $past(err_count) + 1'b1);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

endmodule

bind xlat_cmd_engine xlat_cmd_engine_chk #(.ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .msg_ready(msg_ready), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_id(irq_id), .irq_target(irq_target), .inval_pulse(inval_pulse),
    .sync_done(sync_done), .err_count(err_count), .err_sticky(err_sticky));

// File: tb/tb_xlat_cmd_engine.sv
module tb_xlat_cmd_engine;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [3:0][63:0] cmd_words = '0;
    logic             msg_valid = 1'b0;
    logic             msg_ready;
    logic [31:0]      msg_dev = '0;
    logic [31:0]      msg_evt = '0;
    logic             irq_valid;
    logic             irq_ready = 1'b1;
    logic [31:0]      irq_id;
    logic [31:0]      irq_target;
    logic             inval_pulse;
    logic [31:0]      inval_target;
    logic             sync_done;
    logic [31:0]      sync_target;
    logic [7:0]       err_count;
    logic             err_sticky;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cmd_engine dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_words(cmd_words), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_dev(msg_dev), .msg_evt(msg_evt), .irq_valid(irq_valid),
        .irq_ready(irq_ready), .irq_id(irq_id), .irq_target(irq_target),
        .inval_pulse(inval_pulse), .inval_target(inval_target),
        .sync_done(sync_done), .sync_target(sync_target),
        .err_count(err_count), .err_sticky(err_sticky));

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [3:0][63:0] mk(logic [7:0] op, logic [31:0] dev, logic [31:0] evt,
                                            logic [31:0] intid, logic [15:0] coll,
                                            logic vld, logic [31:0] tgt);
        logic [3:0][63:0] w;
        w[0] = {dev, 24'h0, op};
        w[1] = {intid, evt};
        w[2] = {vld, 15'h0, tgt, coll};
        w[3] = 64'hA5A5_0000_5A5A_FFFF;
        return w;
    endfunction

    // Driver: returns on the negedge after the accepting edge
    task automatic do_cmd(logic [7:0] op, logic [31:0] dev, logic [31:0] evt,
                          logic [31:0] intid, logic [15:0] coll, logic vld, logic [31:0] tgt);
        @(negedge clk);
        cmd_words = mk(op, dev, evt, intid, coll, vld, tgt);
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_msg(logic [31:0] dev, logic [31:0] evt);
        @(negedge clk);
        msg_dev = dev;
        msg_evt = evt;
        msg_valid = 1'b1;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic expect_irq(logic [31:0] id, logic [31:0] tgt);
        exp_q.push_back({id, tgt});
    endtask

    task automatic expect_quiet(string tag);
        repeat (2) @(negedge clk);
        check(tag, {63'd0, irq_valid}, 64'd0);
    endtask

    // Monitor: a valid+ready seen at a negedge completes at the next edge
    always @(negedge clk) begin
        if (!rst && irq_valid && irq_ready) begin
            if (exp_q.size() == 0) begin
                check("R3/R7 unexpected interrupt", {irq_id, irq_target}, 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                check("R3 interrupt id/target", {irq_id, irq_target}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 cmd_ready", {63'd0, cmd_ready}, 64'd1);
        check("R12 irq_valid", {63'd0, irq_valid}, 64'd0);
        check("R12 err_count", {56'd0, err_count}, 64'd0);
        check("R12 err_sticky", {63'd0, err_sticky}, 64'd0);
        check("R12 strobes", {62'd0, sync_done, inval_pulse}, 64'd0);

        // R7 / R12: trigger with empty tables
        do_cmd(8'h03, 0, 0, 0, 0, 0, 0);
        expect_quiet("R7 no irq on empty tables");
        check("R7 sticky set", {63'd0, err_sticky}, 64'd1);

        // R2 / R1 mappings
        do_cmd(8'h09, 0, 0, 0, 16'd1, 1'b1, 32'h0001_2340);
        do_cmd(8'h09, 0, 0, 0, 16'd2, 1'b1, 32'hABCD_0000);
        do_cmd(8'h08, 32'd1, 32'd1, 0, 16'h0, 1'b1, 32'h0);  // size 1: events 0..3
        do_cmd(8'h08, 32'd2, 32'd2, 0, 16'h0, 1'b1, 32'h0);  // size 2: events 0..7

        // R5 boundary
        do_cmd(8'h0A, 32'd1, 32'd3, 32'd8192, 16'd1, 1'b0, 0);
        check("R5 8192 accepted", {56'd0, err_count}, 64'd0);
        do_cmd(8'h0A, 32'd1, 32'd2, 32'd8191, 16'd1, 1'b0, 0);
        check("R5 8191 rejected", {56'd0, err_count}, 64'd1);

        // R6 rejections
        do_cmd(8'h0A, 32'd1, 32'd4, 32'h2100, 16'd1, 1'b0, 0);
        check("R6 event beyond range", {56'd0, err_count}, 64'd2);
        do_cmd(8'h0A, 32'd3, 32'd0, 32'h2100, 16'd1, 1'b0, 0);
        check("R6 unmapped device", {56'd0, err_count}, 64'd3);
        do_cmd(8'h0A, 32'd2, 32'd1, 32'h2100, 16'd3, 1'b0, 0);
        check("R6 unmapped collection", {56'd0, err_count}, 64'd4);
        do_cmd(8'h0A, 32'd9, 32'd0, 32'h2100, 16'd1, 1'b0, 0);
        check("R6 device beyond table", {56'd0, err_count}, 64'd5);

        do_cmd(8'h0A, 32'd2, 32'd7, 32'h3000, 16'd2, 1'b0, 0);
        do_cmd(8'h0A, 32'd2, 32'd0, 32'h2005, 16'd1, 1'b0, 0);

        // R3 triggers
        expect_irq(32'd8192, 32'h0001_2340);
        do_cmd(8'h03, 32'd1, 32'd3, 0, 0, 0, 0);
        expect_irq(32'h3000, 32'hABCD_0000);
        do_cmd(8'h03, 32'd2, 32'd7, 0, 0, 0, 0);
        do_cmd(8'h03, 32'd1, 32'd2, 0, 0, 0, 0);
        expect_quiet("R5 rejected 8191 map not translated");
        do_cmd(8'h03, 32'd1, 32'd4, 0, 0, 0, 0);
        expect_quiet("R1 event beyond range not translated");

        // R4 messages
        expect_irq(32'h2005, 32'h0001_2340);
        do_msg(32'd2, 32'd0);
        do_msg(32'd2, 32'd1);
        expect_quiet("R4 message unmapped pair");

        // R8 back-pressure
        irq_ready = 1'b0;
        expect_irq(32'h3000, 32'hABCD_0000);
        do_cmd(8'h03, 32'd2, 32'd7, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            check("R8 irq held", {63'd0, irq_valid}, 64'd1);
            check("R8 inputs blocked", {62'd0, cmd_ready, msg_ready}, 64'd0);
            check("R3 id stable", {32'd0, irq_id}, 64'h3000);
            @(negedge clk);
        end
        @(posedge clk);
        #1 irq_ready = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 ready restored", {63'd0, cmd_ready}, 64'd1);

        // R4 priority: command pending forces msg_ready low
        @(negedge clk);
        msg_valid = 1'b1;
        msg_dev = 32'd2;
        msg_evt = 32'd0;
        cmd_valid = 1'b1;
        cmd_words = mk(8'h05, 0, 0, 0, 0, 1'b0, 32'h5555_0000);
        #1 check("R4 msg_ready low under command", {63'd0, msg_ready}, 64'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        msg_valid = 1'b0;
        // R9 sync accepted at that edge
        check("R9 sync_done", {63'd0, sync_done}, 64'd1);
        check("R9 sync_target", {32'd0, sync_target}, 64'h5555_0000);
        @(negedge clk);
        check("R9 one-cycle pulse", {63'd0, sync_done}, 64'd0);

        // R10 invalidate-all
        do_cmd(8'h0D, 0, 0, 0, 16'd2, 1'b0, 0);
        check("R10 pulse", {63'd0, inval_pulse}, 64'd1);
        check("R10 target", {32'd0, inval_target}, 64'hABCD_0000);
        @(negedge clk);
        check("R10 one cycle", {63'd0, inval_pulse}, 64'd0);
        do_cmd(8'h0D, 0, 0, 0, 16'd3, 1'b0, 0);
        check("R10 unmapped no pulse", {63'd0, inval_pulse}, 64'd0);

        // R11 unsupported opcodes
        do_cmd(8'h0B, 32'd1, 32'd1, 32'h4000, 16'd2, 1'b1, 32'h1);
        do_cmd(8'h0F, 32'd1, 32'd3, 32'h4000, 16'd1, 1'b0, 0);
        do_cmd(8'h01, 32'd2, 32'd7, 32'h10, 16'd1, 1'b1, 0);
        do_cmd(8'h04, 32'd1, 32'd3, 0, 0, 0, 0);
        do_cmd(8'h0C, 32'd1, 32'd3, 0, 0, 0, 0);
        do_cmd(8'h0E, 32'd1, 32'd3, 0, 16'd1, 1'b0, 0);
        expect_quiet("R11 no interrupt from no-op");
        check("R11 err_count unchanged", {56'd0, err_count}, 64'd5);
        do_cmd(8'h03, 32'd1, 32'd1, 0, 0, 0, 0);
        expect_quiet("R11 no map from 0x0B");
        expect_irq(32'd8192, 32'h0001_2340);
        do_cmd(8'h03, 32'd1, 32'd3, 0, 0, 0, 0);
        expect_irq(32'h3000, 32'hABCD_0000);
        do_msg(32'd2, 32'd7);

        // R2 / R1 unmapping
        do_cmd(8'h09, 0, 0, 0, 16'd1, 1'b0, 32'h0);
        do_cmd(8'h03, 32'd1, 32'd3, 0, 0, 0, 0);
        expect_quiet("R2 unmapped collection stops translation");
        do_cmd(8'h08, 32'd2, 32'd2, 0, 0, 1'b0, 0);
        do_msg(32'd2, 32'd7);
        expect_quiet("R1 unmapped device stops translation");
        check("R7 sticky holds", {63'd0, err_sticky}, 64'd1);

        repeat (3) @(negedge clk);
        check("R3 all expected interrupts seen", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule